// File: doc/BRIEF.md
# Per-CPU Device Interrupt Masking Unit

This block collects up to 64 level-sensitive device interrupt sources into a raw request register and gives each of four CPUs its own 64-bit enable mask. A CPU's masked request is the bitwise AND of its mask with the raw request. The CPU's interrupt line is high while that masked request is nonzero. The output of the cascaded legacy interrupt controller does not share a source pin. It has its own input, and that input owns one fixed bit of the raw request.

Software reaches the block over a 64-bit control/status bus with a 12-bit byte offset. A request is presented with `req_valid`. There is no back-pressure: every request is taken in the cycle it is presented. Exactly one response follows on the next cycle, carrying `rsp_valid`, the read data and an error flag. The masks sit in two separate address groups, one for CPUs 0 and 1 and one for CPUs 2 and 3. Each group also holds the read-only masked views. A fixed set of reserved configuration offsets reads as zero. Any other offset is reported as an error.

Top module: `irq_mask_unit`

## Requirements
- R1: The raw request register holds, one clock after each edge, the levels the sources had at that edge. It reads at offset 0x300.
- R2: Raw bit 55 follows `cascade_irq` alone. The level on `src_level[55]` has no effect on the raw register.
- R3: The mask of CPU0, CPU1, CPU2 and CPU3 is written and read at 0x200, 0x240, 0x600 and 0x640 respectively. A write replaces all 64 bits.
- R4: A read at 0x280, 0x2C0, 0x680 or 0x6C0 (CPU0 to CPU3) returns that CPU's mask AND the raw register.
- R5: `cpu_irq[i]` is high exactly when mask i AND raw is nonzero. It follows a mask write or a source change one clock after the causing edge.
- R6: Writes to the four masked views and to the raw register change nothing and respond without error.
- R7: The reserved offsets read as zero, respond without error and ignore writes. They are 0x000, 0x040, 0x0C0, 0x100/0x140/0x180/0x1C0, 0x340, 0x400/0x440/0x480/0x4C0, 0x580, 0x5C0, 0x780 and 0xC00/0xC40/0xC80/0xCC0.
- R8: Any other offset sets `rsp_err`. A read there returns all ones, and a write there changes nothing.
- R9: After reset all masks, the raw register, `cpu_irq` and `rsp_valid` are zero.
- R10: `rsp_valid` is high in the cycle after each accepted request and low otherwise. A write's response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | 64 | Device interrupt source levels |
| cascade_irq | input | 1 | Cascaded legacy controller output, lands on raw bit 55 |
| req_valid | input | 1 | CSR request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| rsp_err | output | 1 | Offset not decoded |
| cpu_irq | output | 4 | Per-CPU interrupt line |

## Verification
Every result of this block is due one clock after its cause. A response follows its request by one edge. The raw register follows the sampled source levels by one edge. Each interrupt line follows a mask write or a source change by one edge. A read sees the state as it stood before the edge at which it was taken. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge from the same sampled inputs. On the next falling edge it compares every output with the model, so each comparison lands exactly one edge after its stimulus.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    ACC_UNMAPPED = 3'd0,
    ACC_ZERO     = 3'd1,
    ACC_MASK     = 3'd2,
    ACC_VIEW     = 3'd3,
    ACC_RAW      = 3'd4
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [1:0] cpu;
  } acc_dec_t;

  // CPUs 0/1 live in the low group, CPUs 2/3 in the group 0x400 above it.
  function automatic logic [ADDR_W-1:0] mask_offset(input int idx);
    logic [ADDR_W-1:0] base;
    base = (idx >= 2) ? 12'h600 : 12'h200;
    return base + ((idx % 2 == 1) ? 12'h040 : 12'h000);
  endfunction

  function automatic logic [ADDR_W-1:0] view_offset(input int idx);
    return mask_offset(idx) + 12'h080;
  endfunction

  localparam logic [ADDR_W-1:0] RAW_OFFSET = 12'h300;

  function automatic logic is_reserved(input logic [ADDR_W-1:0] a);
    case (a)
      12'h000, 12'h040, 12'h0C0,
      12'h100, 12'h140, 12'h180, 12'h1C0,
      12'h340,
      12'h400, 12'h440, 12'h480, 12'h4C0,
      12'h580, 12'h5C0, 12'h780,
      12'hC00, 12'hC40, 12'hC80, 12'hCC0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic acc_dec_t decode(input logic [ADDR_W-1:0] a, input int n_cpu);
    acc_dec_t d;
    d.kind = ACC_UNMAPPED;
    d.cpu  = 2'd0;
    if (a == RAW_OFFSET) d.kind = ACC_RAW;
    else if (is_reserved(a)) d.kind = ACC_ZERO;
    for (int i = 0; i < 4; i++) begin
      if (i < n_cpu && a == mask_offset(i)) begin
        d.kind = ACC_MASK;
        d.cpu  = 2'(i);
      end
      if (i < n_cpu && a == view_offset(i)) begin
        d.kind = ACC_VIEW;
        d.cpu  = 2'(i);
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/irqm_raw_capture.sv
module irqm_raw_capture #(
  parameter int DATA_W      = 64,
  parameter int CASCADE_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_level,
  input  logic              cascade_irq,
  output logic [DATA_W-1:0] raw_next,
  output logic [DATA_W-1:0] raw_q
);

  // The cascade input owns its bit; the matching source pin is dropped.
  always_comb begin
    raw_next              = src_level;
    raw_next[CASCADE_BIT] = cascade_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next;
  end

endmodule

// File: rtl/irqm_mask_bank.sv
module irqm_mask_bank #(
  parameter int DATA_W = 64,
  parameter int N_CPU  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [1:0]              wr_cpu,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W-1:0]       raw_next,
  output logic [N_CPU*DATA_W-1:0] mask_flat,
  output logic [N_CPU-1:0]        cpu_irq
);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mask_d;
    logic              hit;

    assign hit    = wr_en && (wr_cpu == 2'(i));
    assign mask_d = hit ? wr_data : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q     <= '0;
        cpu_irq[i] <= 1'b0;
      end else begin
        mask_q     <= mask_d;
        // Line evaluated from next-state values so it tracks its cause by one edge.
        cpu_irq[i] <= |(mask_d & raw_next);
      end
    end

    assign mask_flat[i*DATA_W +: DATA_W] = mask_q;
  end

endmodule

// File: rtl/irqm_csr_port.sv
module irqm_csr_port
  import irqm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int N_CPU  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [N_CPU*DATA_W-1:0] mask_flat,
  input  logic [DATA_W-1:0]       raw_q,
  output logic                    wr_en,
  output logic [1:0]              wr_cpu,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_err
);

  acc_dec_t          dec;
  logic [DATA_W-1:0] sel_mask;
  logic [DATA_W-1:0] rd_val;
  logic              bad;

  assign dec = decode(req_addr, N_CPU);
  assign bad = (dec.kind == ACC_UNMAPPED);

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (dec.cpu == 2'(i)) sel_mask = mask_flat[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    case (dec.kind)
      ACC_MASK: rd_val = sel_mask;
      ACC_VIEW: rd_val = sel_mask & raw_q;
      ACC_RAW:  rd_val = raw_q;
      ACC_ZERO: rd_val = '0;
      default:  rd_val = '1;
    endcase
  end

  assign wr_en   = req_valid && req_write && (dec.kind == ACC_MASK);
  assign wr_cpu  = dec.cpu;
  assign wr_data = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_val : '0;
      rsp_err   <= req_valid && bad;
    end
  end

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irqm_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int N_CPU       = 4,
  parameter int CASCADE_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_level,
  input  logic              cascade_irq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [N_CPU-1:0]  cpu_irq
);

  logic [DATA_W-1:0]       raw_next;
  logic [DATA_W-1:0]       raw_q;
  logic [N_CPU*DATA_W-1:0] mask_flat;
  logic                    wr_en;
  logic [1:0]              wr_cpu;
  logic [DATA_W-1:0]       wr_data;

  irqm_raw_capture #(.DATA_W(DATA_W), .CASCADE_BIT(CASCADE_BIT)) u_raw (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .cascade_irq(cascade_irq),
    .raw_next(raw_next), .raw_q(raw_q)
  );

  irqm_mask_bank #(.DATA_W(DATA_W), .N_CPU(N_CPU)) u_masks (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_data(wr_data),
    .raw_next(raw_next), .mask_flat(mask_flat), .cpu_irq(cpu_irq)
  );

  irqm_csr_port #(.DATA_W(DATA_W), .N_CPU(N_CPU)) u_csr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .mask_flat(mask_flat), .raw_q(raw_q),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

endmodule

// File: rtl/irq_mask_unit_chk.sv
module irq_mask_unit_chk #(
  parameter int DATA_W      = 64,
  parameter int N_CPU       = 4,
  parameter int CASCADE_BIT = 55
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [DATA_W-1:0]       src_level,
  input logic                    cascade_irq,
  input logic                    req_valid,
  input logic                    req_write,
  input logic                    rsp_valid,
  input logic [DATA_W-1:0]       rsp_rdata,
  input logic                    rsp_err,
  input logic [N_CPU-1:0]        cpu_irq,
  input logic [DATA_W-1:0]       raw_q,
  input logic [N_CPU*DATA_W-1:0] mask_flat
);

  logic [N_CPU-1:0] pending;
  always_comb begin
    for (int i = 0; i < N_CPU; i++) pending[i] = |(mask_flat[i*DATA_W +: DATA_W] & raw_q);
  end

  // R5: each line agrees with the registered mask and raw state
  a_r5_line_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == pending);

  // R10: one response per request, one edge later
  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R1, R2: raw tracks sampled sources, cascade owns its bit
  a_r1_raw_tracks_src: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q[CASCADE_BIT] == $past(cascade_irq)) &&
             ((raw_q ^ $past(src_level)) & ~(DATA_W'(1) << CASCADE_BIT)) == '0);

  // R8: error flag only on a response; an erroring read returns all ones
  a_r8_err_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r8_err_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> (!rsp_err || rsp_rdata == '1));

  // R3: masks change only when a write is presented
  a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(mask_flat));

endmodule

bind irq_mask_unit irq_mask_unit_chk #(.DATA_W(DATA_W), .N_CPU(N_CPU), .CASCADE_BIT(CASCADE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_level(src_level), .cascade_irq(cascade_irq),
  .req_valid(req_valid), .req_write(req_write), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cpu_irq(cpu_irq),
  .raw_q(raw_q), .mask_flat(mask_flat)
);

// File: tb/tb_irq_mask_unit.sv
`timescale 1ns/1ps
module tb_irq_mask_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_level = '0;
  logic        cascade_irq = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  cpu_irq;

  always #5 clk = ~clk;

  irq_mask_unit dut (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .cascade_irq(cascade_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit live = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench-side address classes: 0 bad, 1 reserved, 2 mask, 3 view, 4 raw
  function automatic int cls(input logic [11:0] a, output int cpu);
    cpu = 0;
    case (a)
      12'h200: begin cpu = 0; return 2; end
      12'h240: begin cpu = 1; return 2; end
      12'h600: begin cpu = 2; return 2; end
      12'h640: begin cpu = 3; return 2; end
      12'h280: begin cpu = 0; return 3; end
      12'h2C0: begin cpu = 1; return 3; end
      12'h680: begin cpu = 2; return 3; end
      12'h6C0: begin cpu = 3; return 3; end
      12'h300: return 4;
      12'h000, 12'h040, 12'h0C0, 12'h100, 12'h140, 12'h180, 12'h1C0, 12'h340,
      12'h400, 12'h440, 12'h480, 12'h4C0, 12'h580, 12'h5C0, 12'h780,
      12'hC00, 12'hC40, 12'hC80, 12'hCC0: return 1;
      default: return 0;
    endcase
  endfunction

  // Behavioural model
  logic [63:0] m_raw;
  logic [63:0] m_mask [4];
  logic [3:0]  m_irq;
  logic        m_rv;
  logic [63:0] m_rd;
  logic        m_err;
  string       m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = '0; m_irq = '0; m_rv = 0; m_rd = '0; m_err = 0; m_tag = "R9";
      for (int i = 0; i < 4; i++) m_mask[i] = '0;
    end else begin
      int c, k;
      m_rv = req_valid; m_rd = '0; m_err = 0; m_tag = "R10";
      if (req_valid) begin
        k = cls(req_addr, c);
        case (k)
          0: begin m_tag = "R8"; m_err = 1; if (!req_write) m_rd = '1; end
          1: m_tag = "R7";
          2: begin m_tag = "R3"; if (!req_write) m_rd = m_mask[c]; end
          3: begin m_tag = req_write ? "R6" : "R4"; if (!req_write) m_rd = m_mask[c] & m_raw; end
          default: begin m_tag = req_write ? "R6" : "R1"; if (!req_write) m_rd = m_raw; end
        endcase
        if (req_write && k == 2) m_mask[c] = req_wdata;
      end
      m_raw = src_level;
      m_raw[55] = cascade_irq;
      for (int i = 0; i < 4; i++) m_irq[i] = |(m_mask[i] & m_raw);
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R5 cpu_irq", {60'd0, cpu_irq}, {60'd0, m_irq});
      chk("R10 rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rv});
      if (m_rv) begin
        chk({m_tag, " rsp_rdata"}, rsp_rdata, m_rd);
        chk({m_tag, " rsp_err"}, {63'd0, rsp_err}, {63'd0, m_err});
      end
    end
  end

  task automatic xfer(input bit wr, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    // R9: reset state seen at the ports
    chk("R9 cpu_irq after reset", {60'd0, cpu_irq}, 64'd0);
    chk("R9 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    xfer(0, 12'h300, '0);
    chk("R9 raw after reset", rsp_rdata, 64'd0);
    xfer(0, 12'h640, '0);
    chk("R9 mask3 after reset", rsp_rdata, 64'd0);

    // R1 / R2: sources and cascade
    src_level = 64'h0080_0000_0000_00F1;
    xfer(0, 12'h300, '0);
    chk("R2 src bit 55 ignored", {63'd0, rsp_rdata[55]}, 64'd0);
    cascade_irq = 1;
    idle(1);
    xfer(0, 12'h300, '0);
    chk("R2 cascade sets bit 55", {63'd0, rsp_rdata[55]}, 64'd1);

    // R3 / R4 / R5: masks
    xfer(1, 12'h200, 64'h0000_0000_0000_0001);
    xfer(1, 12'h240, 64'h0080_0000_0000_0000);
    xfer(1, 12'h600, 64'hFFFF_0000_0000_0000);
    xfer(1, 12'h640, 64'h0000_0000_0000_0100);
    idle(1);
    chk("R5 lines after masks", {60'd0, cpu_irq}, 64'h7);
    xfer(0, 12'h600, '0);
    chk("R3 mask2 readback", rsp_rdata, 64'hFFFF_0000_0000_0000);
    xfer(0, 12'h2C0, '0);
    chk("R4 view1", rsp_rdata, 64'h0080_0000_0000_0000);
    cascade_irq = 0;
    idle(2);
    chk("R5 lines drop with cascade", {60'd0, cpu_irq}, 64'h1);
    src_level = 64'h0000_0000_0000_0100;
    idle(2);
    chk("R5 source moves line", {60'd0, cpu_irq}, 64'h8);

    // R6: read-only registers ignore writes
    xfer(1, 12'h6C0, 64'hDEAD);
    xfer(1, 12'h300, 64'hFFFF_FFFF);
    xfer(0, 12'h300, '0);
    chk("R6 raw unchanged", rsp_rdata, 64'h100);
    xfer(0, 12'h640, '0);
    chk("R6 mask3 unchanged", rsp_rdata, 64'h100);

    // R7: reserved
    xfer(1, 12'h780, '1);
    xfer(0, 12'h780, '0);
    chk("R7 reserved reads zero", rsp_rdata, 64'd0);
    xfer(0, 12'hCC0, '0);
    xfer(0, 12'h000, '0);

    // R8: undecoded
    xfer(0, 12'h208, '0);
    chk("R8 bad read ones", rsp_rdata, '1);
    chk("R8 bad read err", {63'd0, rsp_err}, 64'd1);
    xfer(1, 12'h800, 64'h1234);
    xfer(1, 12'h204, 64'h0);
    xfer(0, 12'h200, '0);
    chk("R8 mask0 untouched", rsp_rdata, 64'h1);

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [11:0] addrs [12];
      int pick;
      addrs = '{12'h200, 12'h240, 12'h600, 12'h640, 12'h280, 12'h2C0,
                12'h680, 12'h6C0, 12'h300, 12'h340, 12'h7C0, 12'hFFF};
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) src_level = {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 5) == 0) cascade_irq = ~cascade_irq;
      pick = $urandom_range(0, 11);
      req_valid = ($urandom_range(0, 2) != 0);
      req_write = $urandom_range(0, 1);
      req_addr  = addrs[pick];
      req_wdata = ($urandom_range(0, 3) == 0) ? 64'd0 : ({$urandom, $urandom} & {$urandom, $urandom});
    end
    @(negedge clk);
    req_valid = 0;
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule